// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Driver Control

This block produces the digital enables for the output transistors of an 8-bit quasi-bidirectional I/O port. Each pin has four drivers: a strong pulldown, a strong pullup that fires briefly, a weak pullup that stays on, and a keeper pullup that follows the sensed pin level. The analog devices and the pin voltage comparator are not part of the block. The comparator result arrives as a digital sensed-pin input.

Software writes a port latch. A 0 in a latch bit pulls the pin low. A 1 releases the pin to the weak pullup, and the pin can then be used as an input. A `stateStart` strobe marks the first oscillator period of every machine state. On that edge the block copies the latch into a shadow register, which acts as a one-state delayed copy of the latch. Any bit that has risen from 0 to 1 since the previous state gets a strong-pullup pulse. The pulse lasts exactly two oscillator periods, which speeds up the rising edge on the pin.

There are two read paths. The read-pin path returns the synchronized pin levels. The read-latch path returns the latch contents, so that read-modify-write operations work on the value that was written.

Top module: `qbp_port`

## Requirements
- R1: While reset is asserted and after it is released, every latch bit is 1. The pulldown enables are all 0, the weak pullup enables are all 1 and the strong pullup enables are all 0.
- R2: `pullDownEn[i]` is 1 exactly when latch bit i holds 0.
- R3: `weakUpEn` and `readLatch` both equal the latch contents at all times.
- R4: When `wrEn` is high at a clock edge, the latch takes `wrData` at that edge. Otherwise the latch holds its value.
- R5: When `stateStart` is high at a clock edge, the latch is copied into the shadow register. For the next two clock cycles, `strongUpEn[i]` is 1 for every bit that was 1 in the latch and 0 in the old shadow. After those two cycles it returns to 0.
- R6: No pulse is produced for a bit that was written 1 while it already held 1 across the previous state boundary, or for a bit written 0. A single rising edge pulses only once.
- R7: `strongUpEn[i]` is 0 whenever latch bit i is 0, so a pin never has its pulldown and its strong pullup enabled in the same cycle.
- R8: A write that lands during an active pulse does not lengthen it. A bit rising to 1 during the pulse is only pulsed at the next `stateStart`.
- R9: `readPin` and `keeperEn` equal `pinIn` delayed by two clock edges. The synchronizer stages reset to all ones.
- R10: When a write and `stateStart` coincide at the same edge, the shadow and the pulse decision use the latch value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stateStart | input | 1 | High during the first oscillator period of each machine state |
| wrEn | input | 1 | Port latch write strobe |
| wrData | input | 8 | Data written to the port latch |
| pinIn | input | 8 | Sensed pin levels from the threshold comparator |
| pullDownEn | output | 8 | Strong pulldown enable per pin |
| strongUpEn | output | 8 | Momentary strong pullup enable per pin |
| weakUpEn | output | 8 | Continuous weak pullup enable per pin |
| keeperEn | output | 8 | Pin-sensed keeper pullup enable per pin |
| readPin | output | 8 | Synchronized pin levels |
| readLatch | output | 8 | Port latch contents |

## Verification
The hardest situations to reach are a write that changes the latch while a pulse is already running, and a write that coincides with the state strobe. Both depend on the exact phase of the write relative to `stateStart`. The stimulus table drives `stateStart` explicitly on chosen cycles, so these phases are placed deliberately. One vector clears a pulsing bit in mid-pulse, which must cut that bit's pulse short. Another raises new bits in mid-pulse, which must not lengthen the pulse. A third writes on the strobe edge itself, which must leave the shadow with the pre-write latch value.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

  // Strobes passed from the timing control to the pin datapath
  typedef struct packed {
    logic capture;   // state boundary: copy latch into shadow, decide pulses
    logic pulseOn;   // strong pullup window is open
  } qbpStrobe_t;

endpackage

// File: rtl/qbp_ctrl.sv
module qbp_ctrl #(
  parameter int PULSE_LEN = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                stateStart,
  output qbp_pkg::qbpStrobe_t strobes
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] pulseCnt;

  // Counts down the pulse window. Every state boundary restarts it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (stateStart) begin
      pulseCnt <= CNT_W'(PULSE_LEN);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_comb begin
    strobes.capture = stateStart;
    strobes.pulseOn = (pulseCnt != '0);
  end
endmodule

// File: rtl/qbp_datapath.sv
module qbp_datapath #(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  qbp_pkg::qbpStrobe_t strobes,
  input  logic                wrEn,
  input  logic [PORT_W-1:0]   wrData,
  input  logic [PORT_W-1:0]   pinIn,
  output logic [PORT_W-1:0]   pullDownEn,
  output logic [PORT_W-1:0]   strongUpEn,
  output logic [PORT_W-1:0]   weakUpEn,
  output logic [PORT_W-1:0]   keeperEn,
  output logic [PORT_W-1:0]   readPin,
  output logic [PORT_W-1:0]   readLatch
);
  localparam logic [PORT_W-1:0] ALL_ONES = {PORT_W{1'b1}};

  logic [PORT_W-1:0] latchQ;
  logic [PORT_W-1:0] shadowQ;
  logic [PORT_W-1:0] pulseBits;
  logic [PORT_W-1:0] syncStage [SYNC_STAGES];

  // Port latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     latchQ <= ALL_ONES;
    else if (wrEn) latchQ <= wrData;
  end

  // One-state delayed copy of the latch, and rising-edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ   <= ALL_ONES;
      pulseBits <= '0;
    end else if (strobes.capture) begin
      shadowQ   <= latchQ;
      pulseBits <= latchQ & ~shadowQ;
    end
  end

  // Pin synchronizer chain
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncStage[s] <= ALL_ONES;
        else if (s == 0) syncStage[s] <= pinIn;
        else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_comb begin
    pullDownEn = ~latchQ;
    weakUpEn   = latchQ;
    // A bit cleared during its window loses its pulse at once
    strongUpEn = pulseBits & latchQ & {PORT_W{strobes.pulseOn}};
    readPin    = syncStage[SYNC_STAGES-1];
    keeperEn   = syncStage[SYNC_STAGES-1];
    readLatch  = latchQ;
  end
endmodule

// File: rtl/qbp_port.sv
module qbp_port #(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_LEN   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stateStart,
  input  logic              wrEn,
  input  logic [PORT_W-1:0] wrData,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] pullDownEn,
  output logic [PORT_W-1:0] strongUpEn,
  output logic [PORT_W-1:0] weakUpEn,
  output logic [PORT_W-1:0] keeperEn,
  output logic [PORT_W-1:0] readPin,
  output logic [PORT_W-1:0] readLatch
);
  qbp_pkg::qbpStrobe_t strobes;

  qbp_ctrl #(.PULSE_LEN(PULSE_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .stateStart(stateStart), .strobes(strobes)
  );

  qbp_datapath #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrEn(wrEn), .wrData(wrData), .pinIn(pinIn),
    .pullDownEn(pullDownEn), .strongUpEn(strongUpEn), .weakUpEn(weakUpEn),
    .keeperEn(keeperEn), .readPin(readPin), .readLatch(readLatch)
  );
endmodule

// File: rtl/qbp_port_checker.sv
module qbp_port_checker #(
  parameter int PORT_W    = 8,
  parameter int PULSE_LEN = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              stateStart,
  input logic              wrEn,
  input logic [PORT_W-1:0] wrData,
  input logic [PORT_W-1:0] pullDownEn,
  input logic [PORT_W-1:0] strongUpEn,
  input logic [PORT_W-1:0] weakUpEn,
  input logic [PORT_W-1:0] keeperEn,
  input logic [PORT_W-1:0] readPin,
  input logic [PORT_W-1:0] readLatch
);
  localparam int AGE_W = $clog2(PULSE_LEN + 2);

  // Edges seen since the last state strobe, saturating above the window
  logic [AGE_W-1:0] sinceStart;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   sinceStart <= AGE_W'(PULSE_LEN + 1);
    else if (stateStart)                         sinceStart <= AGE_W'(1);
    else if (sinceStart != AGE_W'(PULSE_LEN + 1)) sinceStart <= sinceStart + 1'b1;
  end

  p_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pullDownEn & strongUpEn) == '0);

  p_weak_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    weakUpEn == readLatch);

  p_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> readLatch == $past(wrData));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(readLatch));

  p_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strongUpEn != '0) |-> (sinceStart >= AGE_W'(1) && sinceStart <= AGE_W'(PULSE_LEN)));

  p_keeper_r9: assert property (@(posedge clk) disable iff (!rstN)
    keeperEn == readPin);
endmodule

bind qbp_port qbp_port_checker #(.PORT_W(PORT_W), .PULSE_LEN(PULSE_LEN)) uChk (
  .clk(clk), .rstN(rstN), .stateStart(stateStart), .wrEn(wrEn), .wrData(wrData),
  .pullDownEn(pullDownEn), .strongUpEn(strongUpEn), .weakUpEn(weakUpEn),
  .keeperEn(keeperEn), .readPin(readPin), .readLatch(readLatch)
);

// File: tb/sim_qbp_port.sv
module sim_qbp_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stateStart = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] pinIn = 8'hFF;
  logic [7:0] pullDownEn, strongUpEn, weakUpEn, keeperEn, readPin, readLatch;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qbp_port u0 (
    .clk(clk), .rstN(rstN), .stateStart(stateStart), .wrEn(wrEn), .wrData(wrData),
    .pinIn(pinIn), .pullDownEn(pullDownEn), .strongUpEn(strongUpEn),
    .weakUpEn(weakUpEn), .keeperEn(keeperEn), .readPin(readPin), .readLatch(readLatch)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Vector fields: {wrEn, wrData, stateStart, expected pulldown, expected strong pullup}
  localparam int NV = 18;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 8'h0F, 1'b0, 8'hF0, 8'h00},  // R2 R4 write low nibble
    {1'b0, 8'h00, 1'b1, 8'hF0, 8'h00},  // R6 falling bits give no pulse
    {1'b0, 8'h00, 1'b0, 8'hF0, 8'h00},
    {1'b1, 8'hFF, 1'b0, 8'h00, 8'h00},  // R5 rise, pulse waits for strobe
    {1'b0, 8'h00, 1'b1, 8'h00, 8'hF0},  // R5 pulse cycle 1
    {1'b0, 8'h00, 1'b0, 8'h00, 8'hF0},  // R5 pulse cycle 2
    {1'b0, 8'h00, 1'b0, 8'h00, 8'h00},  // R5 ends after two
    {1'b0, 8'h00, 1'b1, 8'h00, 8'h00},  // R6 no second pulse
    {1'b1, 8'h00, 1'b0, 8'hFF, 8'h00},  // R6 write zero
    {1'b0, 8'h00, 1'b1, 8'hFF, 8'h00},
    {1'b1, 8'h55, 1'b0, 8'hAA, 8'h00},
    {1'b0, 8'h00, 1'b1, 8'hAA, 8'h55},  // R5
    {1'b1, 8'h54, 1'b0, 8'hAB, 8'h54},  // R7 cleared bit loses pulse
    {1'b1, 8'hFF, 1'b0, 8'h00, 8'h00},  // R8 new rise not pulsed now
    {1'b0, 8'h00, 1'b1, 8'h00, 8'hAA},  // R8 pulsed at next strobe
    {1'b1, 8'hFF, 1'b0, 8'h00, 8'hAA},  // R6 write 1 onto 1
    {1'b0, 8'h00, 1'b0, 8'h00, 8'h00},  // R8 not extended
    {1'b1, 8'h00, 1'b1, 8'hFF, 8'h00}   // R10 shadow takes pre-write value
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pulldown in reset", pullDownEn, 8'h00);
    check("R1 weak in reset", weakUpEn, 8'hFF);
    check("R1 strong in reset", strongUpEn, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 latch after reset", readLatch, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      wrEn       = VEC[i][25];
      wrData     = VEC[i][24:17];
      stateStart = VEC[i][16];
      @(negedge clk);
      check($sformatf("R2 pulldown vec %0d", i), pullDownEn, VEC[i][15:8]);
      check($sformatf("R5 strong vec %0d", i), strongUpEn, VEC[i][7:0]);
      check($sformatf("R3 weak vec %0d", i), weakUpEn, ~VEC[i][15:8]);
      check($sformatf("R3 readLatch vec %0d", i), readLatch, ~VEC[i][15:8]);
      check($sformatf("R7 overlap vec %0d", i), pullDownEn & strongUpEn, 8'h00);
    end
    wrEn = 1'b0;
    stateStart = 1'b0;

    // R10: after the coincident write the shadow is FF, latch is 00; raise all bits
    wrEn = 1'b1; wrData = 8'hFF;
    @(negedge clk);
    wrEn = 1'b0; stateStart = 1'b1;
    @(negedge clk);
    stateStart = 1'b0;
    check("R10 no pulse after coincident write (shadow FF)", strongUpEn, 8'h00);

    // R4: no write leaves the latch alone
    wrData = 8'h12;
    @(negedge clk);
    check("R4 hold without strobe", readLatch, 8'hFF);

    // R9: two-edge synchronizer
    pinIn = 8'h3C;
    @(negedge clk);
    check("R9 readPin after one edge", readPin, 8'hFF);
    @(negedge clk);
    check("R9 readPin after two edges", readPin, 8'h3C);
    check("R9 keeper follows pin", keeperEn, 8'h3C);

    // R1: reset mid-run restores the latch
    wrEn = 1'b1; wrData = 8'h00;
    @(negedge clk);
    wrEn = 1'b0;
    rstN = 1'b0;
    #1;
    check("R1 latch on async reset", readLatch, 8'hFF);
    check("R1 readPin on reset", readPin, 8'hFF);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule